// File: doc/BRIEF.md
# Bus-Cycle Break Comparator

This block watches one processor bus and raises a break request when an observed bus cycle meets a programmed set of conditions. Four configuration registers set those conditions: a target address, an expected data value, a per-bit data exclusion mask and a condition word. The condition word selects which bus master counts, whether the cycle is an instruction fetch or a data access, its direction, and its operand size. A status register holds a sticky match flag, and software clears that flag by writing 1 to it.

The comparator is a passive monitor. Every cycle that has `bus_valid` high is evaluated. The bus has no ready signal, because the comparator never applies back-pressure and never stalls the bus. Configuration writes take effect one clock after the write. Reads are combinational on `cfg_rd_sel`. A match produces a one-clock `brk_pulse` in the cycle after the matching bus cycle, and `brk_flag` is set on the same edge.

When a byte-size condition is programmed, the byte lane that is compared depends on the target address:
- If bit 0 of the target address is 0 (even), bits 15:8 of the expected data are compared.
- If bit 0 is 1 (odd), bits 7:0 are compared.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset, all five registers read 0 and both `brk_pulse` and `brk_flag` are low. A mask of 0 means every data bit takes part in the comparison.
- R2: Condition bits 7:6 select the bus master. The value 00 disables matching entirely. Any value with bit 6 set accepts only CPU cycles (`bus_master`=0). The value 10 accepts only DMA cycles (`bus_master`=1).
- R3: Condition bits 5:4 select the access kind. 00 accepts nothing, 01 accepts fetch only (`bus_fetch`=1), 10 accepts data access only, and 11 accepts both.
- R4: Condition bits 3:2 select the direction. 00 accepts nothing, 01 accepts read only (`bus_write`=0), 10 accepts write only, and 11 accepts both.
- R5: Condition bits 1:0 select the size. 00 accepts any `bus_size` and ignores the data bus completely. 01 (byte), 10 (word) and 11 (longword) require `bus_size` to hold the same code, and they enable the data comparison.
- R6: A match requires `bus_valid`=1 and `bus_addr` equal to the target address in all 32 bits.
- R7: A data bit whose mask bit is 1 is excluded from the comparison.
- R8: Which data bits are compared depends on the size:
  - Byte size compares bits 15:8 when the target address is even, and bits 7:0 when it is odd.
  - Word size compares bits 15:0.
  - Longword size compares bits 31:0.
- R9: Each matching bus cycle produces `brk_pulse`=1 for exactly the following clock cycle and sets `brk_flag` on that same edge.
- R10: Writing 1 to bit 0 of status register 4 clears `brk_flag`. Writing 0 to that bit has no effect. A match in the same cycle as the clear write leaves the flag set.
- R11: Bits 15:8 of condition register 3 always read 0 and ignore writes.
- R12: The register map is: 0 = target address, 1 = expected data, 2 = mask, 3 = condition, 4 = status (bit 0 holds the flag). A write becomes visible on readback one clock after the write. Selects 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select for writes |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 3 | Register select for reads |
| cfg_rd_data | output | 32 | Read data, combinational on cfg_rd_sel |
| bus_valid | input | 1 | An observed bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| bus_master | input | 1 | 0 = CPU, 1 = DMA |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 01 = byte, 10 = word, 11 = longword |
| brk_pulse | output | 1 | One-clock break request |
| brk_flag | output | 1 | Sticky match flag |

## Verification
The assertions assume that the bus fields are stable and meaningful whenever `bus_valid` is high, and that register selects are within 0 to 7. The stimulus drives all inputs at the falling clock edge and holds them for a full cycle, so both assumptions always hold. Random bus cycles reuse the programmed address, and they flip only masked data bits, often enough that matches, near-misses and clear-versus-set collisions all occur. Directed cycles pin down each byte lane, each master encoding and the case where data is ignored.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [2:0] {
    SEL_TADDR = 3'd0,
    SEL_TDATA = 3'd1,
    SEL_XMASK = 3'd2,
    SEL_COND  = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  typedef struct packed {
    logic [1:0] master;
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } cond_t;
endpackage

// File: rtl/bcmp_regs.sv
module bcmp_regs
  import bcmp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  input  logic          flag_i,
  output logic [DW-1:0] rd_data,
  output logic          clr_o,
  output logic [AW-1:0] taddr_o,
  output logic [DW-1:0] tdata_o,
  output logic [DW-1:0] xmask_o,
  output cond_t         cond_o
);
  localparam int unsigned CW = $bits(cond_t);

  logic [AW-1:0] taddr_q;
  logic [DW-1:0] tdata_q;
  logic [DW-1:0] xmask_q;
  cond_t         cond_q;

  logic wr_taddr, wr_tdata, wr_xmask, wr_cond;

  assign wr_taddr = wr_en && (wr_sel == SEL_TADDR);
  assign wr_tdata = wr_en && (wr_sel == SEL_TDATA);
  assign wr_xmask = wr_en && (wr_sel == SEL_XMASK);
  assign wr_cond  = wr_en && (wr_sel == SEL_COND);
  assign clr_o    = wr_en && (wr_sel == SEL_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr_q <= '0;
      tdata_q <= '0;
      xmask_q <= '0;
      cond_q  <= '0;
    end else begin
      if (wr_taddr) taddr_q <= wr_data[AW-1:0];
      if (wr_tdata) tdata_q <= wr_data;
      if (wr_xmask) xmask_q <= wr_data;
      if (wr_cond)  cond_q  <= cond_t'(wr_data[CW-1:0]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_TADDR: rd_data = DW'(taddr_q);
      SEL_TDATA: rd_data = tdata_q;
      SEL_XMASK: rd_data = xmask_q;
      SEL_COND:  rd_data = DW'(cond_q);
      SEL_STAT:  rd_data = DW'(flag_i);
      default:   rd_data = '0;
    endcase
  end

  assign taddr_o = taddr_q;
  assign tdata_o = tdata_q;
  assign xmask_o = xmask_q;
  assign cond_o  = cond_q;

  // R12: a target address write is visible one clock later
  assert_taddr_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TADDR) |=> (taddr_o == $past(wr_data[AW-1:0])));

  // R11: only the low condition byte is captured
  assert_cond_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_COND) |=> (rd_sel != SEL_COND || rd_data[15:8] == 8'h00));
endmodule

// File: rtl/bcmp_match.sv
module bcmp_match
  import bcmp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  cond_t         cond_i,
  input  logic [AW-1:0] taddr_i,
  input  logic [DW-1:0] tdata_i,
  input  logic [DW-1:0] xmask_i,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_master,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  output logic          hit_o
);
  localparam logic [DW-1:0] LANE_LO   = DW'(16'h00FF);
  localparam logic [DW-1:0] LANE_HI   = DW'(16'hFF00);
  localparam logic [DW-1:0] LANE_HALF = DW'(16'hFFFF);

  logic          master_ok, kind_ok, dir_ok, addr_ok, size_ok, data_ok;
  logic [DW-1:0] lane;
  logic [DW-1:0] diff;

  always_comb begin
    if (cond_i.master == 2'b00)  master_ok = 1'b0;
    else if (cond_i.master[0])   master_ok = (bus_master == 1'b0);
    else                         master_ok = (bus_master == 1'b1);
  end

  assign kind_ok = bus_fetch ? cond_i.kind[0] : cond_i.kind[1];
  assign dir_ok  = bus_write ? cond_i.dir[1]  : cond_i.dir[0];
  assign addr_ok = (bus_addr == taddr_i);

  always_comb begin
    case (size_e'(cond_i.size))
      SZ_BYTE: lane = taddr_i[0] ? LANE_LO : LANE_HI;
      SZ_WORD: lane = LANE_HALF;
      SZ_LONG: lane = '1;
      default: lane = '0;
    endcase
  end

  assign diff    = (bus_data ^ tdata_i) & lane & ~xmask_i;
  assign size_ok = (cond_i.size == SZ_ANY) || (bus_size == cond_i.size);
  assign data_ok = (cond_i.size == SZ_ANY) || (diff == '0);
  assign hit_o   = bus_valid && master_ok && kind_ok && dir_ok && addr_ok && size_ok && data_ok;
endmodule

// File: rtl/bcmp_flag.sv
module bcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic flag_o
);
  logic pulse_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= hit_i;
      flag_q  <= hit_i | (flag_q & ~clr_i);
    end
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;

  // R10: without a clear the flag never drops
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_o) && !$past(clr_i)) |-> flag_o);

  // R9: a pulse always comes with the flag set
  assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> flag_o);
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
  import bcmp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [2:0]    cfg_wr_sel,
  input  logic [DW-1:0] cfg_wr_data,
  input  logic [2:0]    cfg_rd_sel,
  output logic [DW-1:0] cfg_rd_data,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_master,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  output logic          brk_pulse,
  output logic          brk_flag
);
  logic [AW-1:0] taddr;
  logic [DW-1:0] tdata, xmask;
  cond_t         cond;
  logic          clr, hit;

  bcmp_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_sel(cfg_rd_sel), .flag_i(brk_flag), .rd_data(cfg_rd_data),
    .clr_o(clr), .taddr_o(taddr), .tdata_o(tdata), .xmask_o(xmask), .cond_o(cond)
  );

  bcmp_match #(.AW(AW), .DW(DW)) u_match (
    .cond_i(cond), .taddr_i(taddr), .tdata_i(tdata), .xmask_i(xmask),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_master(bus_master), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_size(bus_size), .hit_o(hit)
  );

  bcmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr),
    .pulse_o(brk_pulse), .flag_o(brk_flag)
  );

  // R2: master select 00 disables the channel
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cond.master) == 2'b00) |-> !brk_pulse);

  // R6: a pulse needs a valid cycle on the target address
  assert_pulse_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(bus_valid && bus_addr == taddr));
endmodule

// File: tb/bus_break_matcher_tb_top.sv
module bus_break_matcher_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [2:0]    cfg_wr_sel = '0;
  logic [DW-1:0] cfg_wr_data = '0;
  logic [2:0]    cfg_rd_sel = '0;
  logic [DW-1:0] cfg_rd_data;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          bus_master = 1'b0;
  logic          bus_fetch = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_size = '0;
  logic          brk_pulse, brk_flag;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_addr = '0, m_data = '0, m_mask = '0;
  logic [7:0]  m_cond = '0;
  logic        m_flag = 1'b0;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  bus_break_matcher #(.AW(AW), .DW(DW)) dut_i (.*);

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish (actual running, expected done)");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic bit model_hit(bit v, logic [31:0] a, logic [31:0] d,
                                   bit mst, bit f, bit w, logic [1:0] sz);
    logic [31:0] lane;
    if (!v) return 1'b0;
    if (m_cond[7:6] == 2'b00) return 1'b0;
    if (m_cond[6]) begin if (mst != 1'b0) return 1'b0; end
    else if (mst != 1'b1) return 1'b0;
    if (f && !m_cond[4]) return 1'b0;
    if (!f && !m_cond[5]) return 1'b0;
    if (!w && !m_cond[2]) return 1'b0;
    if (w && !m_cond[3]) return 1'b0;
    if (a != m_addr) return 1'b0;
    if (m_cond[1:0] != 2'b00) begin
      if (sz != m_cond[1:0]) return 1'b0;
      case (m_cond[1:0])
        2'b01:   lane = m_addr[0] ? 32'h0000_00FF : 32'h0000_FF00;
        2'b10:   lane = 32'h0000_FFFF;
        default: lane = 32'hFFFF_FFFF;
      endcase
      if (((d ^ m_data) & lane & ~m_mask) != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] val);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    case (sel)
      3'd0: m_addr = val;
      3'd1: m_data = val;
      3'd2: m_mask = val;
      3'd3: m_cond = val[7:0];
      3'd4: if (val[0]) m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [2:0] sel, logic [31:0] exp);
    cfg_rd_sel = sel;
    #1;
    check(req, cfg_rd_data, exp);
  endtask

  task automatic step(string req, bit v, logic [31:0] a, logic [31:0] d,
                      bit mst, bit f, bit w, logic [1:0] sz, bit clr);
    bit e;
    bus_valid = v; bus_addr = a; bus_data = d; bus_master = mst;
    bus_fetch = f; bus_write = w; bus_size = sz;
    cfg_wr_en = clr; cfg_wr_sel = 3'd4; cfg_wr_data = 32'h1;
    e = model_hit(v, a, d, mst, f, w, sz);
    @(negedge clk);
    bus_valid = 1'b0; cfg_wr_en = 1'b0;
    m_flag = e | (m_flag & ~clr);
    check({req, " pulse"}, {31'd0, brk_pulse}, {31'd0, e});
    check({req, " flag"},  {31'd0, brk_flag},  {31'd0, m_flag});
  endtask

  initial begin
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 5; s++) rd("R1 reset read", 3'(s), 32'h0);
    check("R1 pulse at reset", {31'd0, brk_pulse}, 32'h0);
    check("R1 flag at reset",  {31'd0, brk_flag},  32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: map and readback
    wr(3'd0, 32'h1234_5678); rd("R12 addr", 3'd0, 32'h1234_5678);
    wr(3'd1, 32'hCAFE_F00D); rd("R12 data", 3'd1, 32'hCAFE_F00D);
    wr(3'd2, 32'h0F0F_0000); rd("R12 mask", 3'd2, 32'h0F0F_0000);
    wr(3'd6, 32'hFFFF_FFFF); rd("R12 unused sel", 3'd6, 32'h0);
    // R11: reserved condition bits
    wr(3'd3, 32'hFFFF_FFFF); rd("R11 cond reserved", 3'd3, 32'h0000_00FF);

    // R2: master select
    wr(3'd2, 32'h0); wr(3'd0, 32'h0000_1000);
    wr(3'd3, 32'h0000_003C);
    step("R2 disabled", 1, 32'h1000, 0, 0, 1, 0, 2'b01, 0);
    wr(3'd3, 32'h0000_00FC);
    step("R2 cpu via 11", 1, 32'h1000, 0, 0, 0, 1, 2'b11, 0);
    step("R2 dma rejected by 11", 1, 32'h1000, 0, 1, 0, 1, 2'b11, 0);
    wr(3'd3, 32'h0000_00BC);
    step("R2 dma via 10", 1, 32'h1000, 0, 1, 1, 0, 2'b10, 0);
    // R10: clear and set-wins
    wr(3'd4, 32'h0); rd("R10 write 0 keeps flag", 3'd4, 32'h1);
    wr(3'd4, 32'h1); rd("R10 write 1 clears", 3'd4, 32'h0);
    step("R10 set wins", 1, 32'h1000, 0, 1, 1, 0, 2'b10, 1);
    // R3 / R4: kind and direction
    wr(3'd3, 32'h0000_0058);
    step("R3 fetch-only rejects data", 1, 32'h1000, 0, 0, 0, 1, 2'b01, 0);
    step("R4 write-only rejects read", 1, 32'h1000, 0, 0, 1, 0, 2'b01, 0);
    step("R3 R4 fetch write", 1, 32'h1000, 0, 0, 1, 1, 2'b01, 0);
    // R6: valid and address
    wr(3'd3, 32'h0000_007C);
    step("R6 no valid", 0, 32'h1000, 0, 0, 1, 1, 2'b01, 0);
    step("R6 addr differs", 1, 32'h9000_1000, 0, 0, 1, 1, 2'b01, 0);
    // R5 / R8: sizes and lanes
    wr(3'd1, 32'h0000_AB00);
    wr(3'd3, 32'h0000_007D);
    step("R8 byte even lane", 1, 32'h1000, 32'hFFFF_AB77, 0, 0, 0, 2'b01, 0);
    step("R5 size mismatch", 1, 32'h1000, 32'h0000_AB00, 0, 0, 0, 2'b10, 0);
    wr(3'd0, 32'h0000_1001); wr(3'd1, 32'h0000_00CD);
    step("R8 byte odd lane", 1, 32'h1001, 32'h1234_56CD, 0, 0, 0, 2'b01, 0);
    step("R8 odd lane miss", 1, 32'h1001, 32'h0000_00CC, 0, 0, 0, 2'b01, 0);
    wr(3'd3, 32'h0000_007C);
    step("R5 any size ignores data", 1, 32'h1001, 32'hDEAD_BEEF, 0, 0, 0, 2'b11, 0);
    // R7: mask
    wr(3'd1, 32'h1234_5678); wr(3'd2, 32'hF000_000F); wr(3'd3, 32'h0000_007F);
    step("R7 masked bits differ", 1, 32'h1001, 32'hE234_5677, 0, 0, 0, 2'b11, 0);
    step("R7 unmasked bit differs", 1, 32'h1001, 32'h1234_5778, 0, 0, 0, 2'b11, 0);
    step("R9 back-to-back", 1, 32'h1001, 32'h1234_5678, 0, 0, 0, 2'b11, 0);
    step("R9 pulse one cycle", 0, 32'h1001, 32'h1234_5678, 0, 0, 0, 2'b11, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, d;
      if (i % 200 == 0) begin
        wr(3'd0, ($urandom % 2) ? $urandom : {$urandom} & 32'h0000_00FF);
        wr(3'd1, $urandom);
        wr(3'd2, ($urandom % 3 == 0) ? $urandom : 32'h0);
        wr(3'd3, {24'h0, 2'(($urandom % 3) + 1), 4'hF, 2'($urandom)});
      end
      a = ($urandom % 4 != 0) ? m_addr : $urandom;
      d = ($urandom % 3 != 0) ? (m_data ^ ($urandom & m_mask)) : $urandom;
      step("R9 random", ($urandom % 8) != 0, a, d, 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), ($urandom % 10) == 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule